// File: doc/BRIEF.md
# Flash Device Identification Probe

This block finds out which byte-wide parallel NOR flash sits on its bus. Right after reset, and again whenever a start pulse arrives while it is idle, it runs one identification sequence. It writes the read-identifier command, waits a settle time, and reads two identifier bytes. It then writes the command that puts the array back into normal read mode. The two bytes are joined into a 16-bit identifier. The block decodes the identifier into a valid flag and a capacity code.

The bus is a simple synchronous master. It has an address, write data, read data, a one-cycle write strobe, and a read strobe that is held for a fixed number of cycles. The address and read data change only with the clock. The settle wait and the read latency are cycle counts set by parameters. The block has no model of real flash timing.

The first identifier byte decides where the second one is read. A first byte equal to the wide-part tag makes the block read the second byte from offset 2. Any other first byte sends the read to offset 1.

Top module: `flash_id_probe`

## Requirements
- R1: While rst_n is low, done, id, id_valid, size_code, fl_we and fl_re are all 0. After reset is released, a probe starts without any start pulse.
- R2: A probe begins with a one-cycle write of command byte 0x90 to offset CMD_OFS (default 0x8000). Every write strobe addresses CMD_OFS.
- R3: No read strobe is driven during the SETTLE_CYC cycles after the 0x90 write cycle. The first read cycle comes SETTLE_CYC+1 cycles after the write cycle.
- R4: Each read holds fl_re and a steady address for RD_LAT cycles. The data is sampled in the last of those cycles. The first read is at offset 0, and its byte becomes id[15:8]. A probe uses exactly 2*RD_LAT read cycles, and fl_we and fl_re are never high together.
- R5: The second read goes to offset 2 when the first byte equals 0xB0, and to offset 1 otherwise. Its byte becomes id[7:0].
- R6: After the two reads, command byte 0xFF is written once to CMD_OFS. This returns the device to array read mode.
- R7: Identifier 0x89A6 gives id_valid=1 and size_code=1 (1 MiB). Identifier 0xB0D4 gives id_valid=1 and size_code=2 (4 MiB). Any other value gives id_valid=0 and size_code=0. id always shows the two bytes as read.
- R8: done is high for exactly one cycle, the cycle after the 0xFF write. id, id_valid and size_code take their new values in that same cycle and hold them until the next accepted start.
- R9: A start pulse that arrives while a probe is running is ignored. No second command sequence is issued, and only one done pulse follows.
- R10: A start pulse sampled while idle starts a new probe. In the next cycle the 0x90 write is on the bus and id, id_valid and size_code read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new probe (taken only when idle) |
| done | output | 1 | One-cycle pulse when a probe completes |
| id | output | 16 | Identifier, first byte in the upper half |
| id_valid | output | 1 | Identifier is one of the two known parts |
| size_code | output | 2 | 0 none, 1 = 1 MiB, 2 = 4 MiB |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_wdata | output | 8 | Command byte written to the flash |
| fl_rdata | input | 8 | Byte returned by the flash |
| fl_we | output | 1 | Write strobe, one cycle per command |
| fl_re | output | 1 | Read strobe, held for RD_LAT cycles per byte |

## Verification
The hardest case to reach is a sequence that gives the right identifier for the wrong reason. Examples are a second read from the wrong offset, data sampled before the read latency has elapsed, or reads issued outside identifier mode. The bench flash model guards against all three. It returns identifier bytes only between the 0x90 and 0xFF commands, and only once the read strobe has been steady for RD_LAT cycles; otherwise it returns a poison byte. Its vectors place different bytes at offsets 1 and 2, so an offset error shows up as a wrong identifier. A start pulse is injected in the middle of the settle wait to show that it is ignored.

// File: rtl/fidp_pkg.sv
package fidp_pkg;

  typedef enum logic [2:0] {
    PS_LAUNCH,
    PS_IDLE,
    PS_CMD_ID,
    PS_SETTLE,
    PS_RD_HI,
    PS_RD_LO,
    PS_CMD_RD
  } probe_st_e;

  typedef enum logic [1:0] {
    SZ_NONE = 2'd0,
    SZ_1MIB = 2'd1,
    SZ_4MIB = 2'd2
  } cap_e;

  localparam logic [7:0] CMD_READ_ID = 8'h90;
  localparam logic [7:0] CMD_ARRAY   = 8'hFF;

  // Offset of the second identifier byte, chosen by the first byte.
  function automatic logic [1:0] lo_byte_offset(input logic [7:0] hi_byte,
                                                input logic [7:0] wide_tag);
    return (hi_byte == wide_tag) ? 2'd2 : 2'd1;
  endfunction

  // Map a 16-bit identifier to a capacity class.
  function automatic cap_e classify(input logic [15:0] ident,
                                    input logic [15:0] id_small,
                                    input logic [15:0] id_large);
    if (ident == id_small)      return SZ_1MIB;
    else if (ident == id_large) return SZ_4MIB;
    else                        return SZ_NONE;
  endfunction

endpackage

// File: rtl/fidp_timer.sv
module fidp_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R3
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> !expired);

endmodule

// File: rtl/fidp_id_decode.sv
module fidp_id_decode
  import fidp_pkg::*;
#(
  parameter logic [15:0] ID_SMALL = 16'h89A6,
  parameter logic [15:0] ID_LARGE = 16'hB0D4
) (
  input  logic [15:0] ident,
  output logic        known,
  output cap_e        cap
);
  always_comb begin
    cap   = classify(ident, ID_SMALL, ID_LARGE);
    known = (cap != SZ_NONE);
  end
endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe
  import fidp_pkg::*;
#(
  parameter int              ADDR_W     = 22,
  parameter int              SETTLE_CYC = 3750,
  parameter int              RD_LAT     = 2,
  parameter logic [ADDR_W-1:0] CMD_OFS  = 'h8000,
  parameter logic [7:0]      WIDE_TAG   = 8'hB0,
  parameter logic [15:0]     ID_SMALL   = 16'h89A6,
  parameter logic [15:0]     ID_LARGE   = 16'hB0D4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic [15:0]       id,
  output logic              id_valid,
  output logic [1:0]        size_code,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  input  logic [7:0]        fl_rdata,
  output logic              fl_we,
  output logic              fl_re
);
  localparam int MAX_DUR = (SETTLE_CYC > RD_LAT) ? SETTLE_CYC : RD_LAT;
  localparam int CNT_W   = $clog2(MAX_DUR + 1);

  probe_st_e state, state_n;
  logic      tmr_exp, tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic [7:0] hi_q, lo_q;
  logic       dec_known;
  cap_e       dec_cap;

  // Named internal events
  logic probe_go, cmd_id_evt, cmd_rd_evt, cap_hi_evt, cap_lo_evt, rd_hi_ph, rd_lo_ph;
  assign probe_go   = (state == PS_IDLE) && start;
  assign cmd_id_evt = (state == PS_CMD_ID);
  assign cmd_rd_evt = (state == PS_CMD_RD);
  assign rd_hi_ph   = (state == PS_RD_HI);
  assign rd_lo_ph   = (state == PS_RD_LO);
  assign cap_hi_evt = rd_hi_ph && tmr_exp;
  assign cap_lo_evt = rd_lo_ph && tmr_exp;

  always_comb begin
    state_n = state;
    unique case (state)
      PS_LAUNCH: state_n = PS_CMD_ID;
      PS_IDLE:   if (start)   state_n = PS_CMD_ID;
      PS_CMD_ID: state_n = PS_SETTLE;
      PS_SETTLE: if (tmr_exp) state_n = PS_RD_HI;
      PS_RD_HI:  if (tmr_exp) state_n = PS_RD_LO;
      PS_RD_LO:  if (tmr_exp) state_n = PS_CMD_RD;
      PS_CMD_RD: state_n = PS_IDLE;
      default:   state_n = PS_IDLE;
    endcase
  end

  // Timer reload on every state change, with the new state's duration minus one
  always_comb begin
    tmr_load = (state_n != state);
    case (state_n)
      PS_SETTLE:          tmr_val = CNT_W'(SETTLE_CYC - 1);
      PS_RD_HI, PS_RD_LO: tmr_val = CNT_W'(RD_LAT - 1);
      default:            tmr_val = '0;
    endcase
  end

  fidp_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= PS_LAUNCH;
      hi_q  <= '0;
      lo_q  <= '0;
    end else begin
      state <= state_n;
      if (cap_hi_evt) hi_q <= fl_rdata;
      if (cap_lo_evt) lo_q <= fl_rdata;
    end
  end

  // Bus drive
  always_comb begin
    fl_we    = cmd_id_evt || cmd_rd_evt;
    fl_re    = rd_hi_ph || rd_lo_ph;
    fl_wdata = cmd_rd_evt ? CMD_ARRAY : (cmd_id_evt ? CMD_READ_ID : 8'h00);
    if (fl_we)         fl_addr = CMD_OFS;
    else if (rd_lo_ph) fl_addr = ADDR_W'(lo_byte_offset(hi_q, WIDE_TAG));
    else               fl_addr = '0;
  end

  fidp_id_decode #(.ID_SMALL(ID_SMALL), .ID_LARGE(ID_LARGE)) u_dec (
    .ident({hi_q, lo_q}), .known(dec_known), .cap(dec_cap)
  );

  // Result registers: cleared on an accepted start, loaded at the end write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done      <= 1'b0;
      id        <= '0;
      id_valid  <= 1'b0;
      size_code <= SZ_NONE;
    end else begin
      done <= cmd_rd_evt;
      if (probe_go) begin
        id        <= '0;
        id_valid  <= 1'b0;
        size_code <= SZ_NONE;
      end else if (cmd_rd_evt) begin
        id        <= {hi_q, lo_q};
        id_valid  <= dec_known;
        size_code <= dec_cap;
      end
    end
  end

  // R2
  we_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we |-> (fl_addr == CMD_OFS));
  // R4
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));
  // R3
  settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && fl_wdata == CMD_READ_ID) |=> !fl_re);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  done_after_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && fl_wdata == CMD_ARRAY) |=> done);
  // R7
  valid_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |-> (size_code != 2'd0));

endmodule

// File: tb/tb_flash_id_probe.sv
module tb_flash_id_probe;
  localparam int ADDR_W = 22;
  localparam int SETTLE = 6;
  localparam int RDL    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done, id_valid, fl_we, fl_re;
  logic [15:0] id;
  logic [1:0] size_code;
  logic [ADDR_W-1:0] fl_addr;
  logic [7:0] fl_wdata, fl_rdata;

  always #2 clk = ~clk;  // 250 MHz

  flash_id_probe #(.ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE), .RD_LAT(RDL)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .id(id),
    .id_valid(id_valid), .size_code(size_code), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_rdata(fl_rdata), .fl_we(fl_we), .fl_re(fl_re)
  );

  // Flash model
  logic [7:0] m_b0 = 8'h89, m_b1 = 8'hA6, m_b2 = 8'h11;
  logic idm = 1'b0;
  logic prev_re = 1'b0;
  logic [ADDR_W-1:0] prev_addr = '0;
  int prev_idx = 0;
  int seg_idx;

  always_comb begin
    seg_idx = (fl_re && prev_re && fl_addr == prev_addr) ? prev_idx + 1 : 0;
    if (fl_re && !idm)                    fl_rdata = 8'h3C;
    else if (fl_re && seg_idx >= RDL - 1) begin
      case (fl_addr)
        22'd0:   fl_rdata = m_b0;
        22'd1:   fl_rdata = m_b1;
        22'd2:   fl_rdata = m_b2;
        default: fl_rdata = 8'h00;
      endcase
    end else                              fl_rdata = 8'hEE;
  end

  // Monitor
  int cyc = 0, n90 = 0, nff = 0, nre = 0, nseg = 0, ndone = 0, t90 = 0, tre = 0;
  logic [ADDR_W-1:0] seg_addr [4];

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (fl_we && fl_wdata == 8'h90) begin n90 = n90 + 1; t90 = cyc; idm <= 1'b1; end
      if (fl_we && fl_wdata == 8'hFF) begin nff = nff + 1; idm <= 1'b0; end
      if (fl_re && !prev_re) tre = cyc;
      if (fl_re) nre = nre + 1;
      if (fl_re && seg_idx == 0) begin seg_addr[nseg % 4] = fl_addr; nseg = nseg + 1; end
      if (done) ndone = ndone + 1;
    end
    prev_re   <= fl_re;
    prev_addr <= fl_addr;
    prev_idx  <= seg_idx;
  end

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    n90 = 0; nff = 0; nre = 0; nseg = 0; ndone = 0;
  endtask

  task automatic wait_done(output bit got);
    got = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (done) begin got = 1'b1; break; end
    end
  endtask

  task automatic check_seq(input logic [7:0] b0);
    logic [ADDR_W-1:0] exp_off;
    exp_off = (b0 == 8'hB0) ? 22'd2 : 22'd1;
    chk(n90 == 1, "R2 one ID command", n90, 1);
    chk(tre - t90 == SETTLE + 1, "R3 settle gap", tre - t90, SETTLE + 1);
    chk(nre == 2 * RDL, "R4 read cycles", nre, 2 * RDL);
    chk(nseg == 2 && seg_addr[0] == 0, "R4 first read offset 0", seg_addr[0], 0);
    chk(seg_addr[1] == exp_off, "R5 second read offset", seg_addr[1], exp_off);
    chk(nff == 1 && idm == 1'b0, "R6 return to array mode", nff, 1);
  endtask

  typedef struct packed {
    logic [7:0] b0, b1, b2;
    logic [15:0] eid;
    logic ev;
    logic [1:0] esz;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'h89, 8'hA6, 8'h11, 16'h89A6, 1'b1, 2'd1},
    '{8'hB0, 8'h55, 8'hD4, 16'hB0D4, 1'b1, 2'd2},
    '{8'hB0, 8'hD4, 8'h77, 16'hB077, 1'b0, 2'd0},
    '{8'h89, 8'h12, 8'hA6, 16'h8912, 1'b0, 2'd0},
    '{8'h12, 8'h34, 8'h56, 16'h1234, 1'b0, 2'd0},
    '{8'hB0, 8'h01, 8'hA6, 16'hB0A6, 1'b0, 2'd0}
  };

  initial begin
    bit got;
    // R1 reset state
    repeat (4) @(negedge clk);
    chk(done == 0 && id == 0 && id_valid == 0 && size_code == 0, "R1 reset outputs",
        {id, 3'b0, done, id_valid, size_code}, 0);
    chk(fl_we == 0 && fl_re == 0, "R1 reset bus idle", {fl_we, fl_re}, 0);
    clr_mon();
    rst_n = 1'b1;
    wait_done(got);
    chk(got, "R1 automatic probe after reset", got, 1);
    check_seq(8'h89);
    chk(id == 16'h89A6 && id_valid && size_code == 2'd1, "R7 reset probe result", id, 16'h89A6);

    // Vector table
    foreach (VECS[k]) begin
      m_b0 = VECS[k].b0; m_b1 = VECS[k].b1; m_b2 = VECS[k].b2;
      clr_mon();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(fl_we && fl_wdata == 8'h90, "R10 start launches probe", fl_wdata, 8'h90);
      chk(id == 0 && !id_valid && size_code == 0, "R8 outputs cleared on start", id, 0);
      wait_done(got);
      chk(got, "R8 done arrives", got, 1);
      chk(id == VECS[k].eid, "R7 id value", id, VECS[k].eid);
      chk(id_valid == VECS[k].ev, "R7 valid flag", id_valid, VECS[k].ev);
      chk(size_code == VECS[k].esz, "R7 size code", size_code, VECS[k].esz);
      check_seq(VECS[k].b0);
      @(negedge clk);
      chk(!done, "R8 done one cycle", done, 0);
      repeat (8) @(negedge clk);
      chk(id == VECS[k].eid && id_valid == VECS[k].ev, "R8 outputs held", id, VECS[k].eid);
    end

    // R9: start during a running probe
    m_b0 = 8'hB0; m_b1 = 8'h00; m_b2 = 8'hD4;
    clr_mon();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(got);
    repeat (30) @(negedge clk);
    chk(n90 == 1, "R9 no second ID command", n90, 1);
    chk(ndone == 1, "R9 single done", ndone, 1);
    chk(id == 16'hB0D4 && size_code == 2'd2, "R9 result intact", id, 16'hB0D4);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule